// File: doc/BRIEF.md
# Power Event Status Capture Register

This block holds a small byte of sticky status flags in the always-powered domain. Each flag records one power or reset event: a press of the system reset button, a processor thermal trip, a drop of the main power-good signal, or a drop of the processor regulator's power-good. Software reads the byte on `status_o`. It clears a flag by writing a 1 to that flag's bit through a one-cycle write strobe. The event pins arrive asynchronously and each passes through a two-flop synchronizer. A flag sets on the qualified active edge of its input, not on its level.

Each flag follows its own rules. It sets only in particular sleep states, and it is cleared by its own hardware sources. The block also sorts each main power-good outage into one of two kinds. In a partial outage, power-good returns while the resume-well reset stays idle, and the block always requests a reboot. In a full outage, the resume-well reset asserts at some point during the outage, and the reboot request then depends on the after-power-loss policy input.

Top module: `pwr_evt_status`

## Requirements
- R1: After reset, `status_o` is 00h. Bits 7, 6, 5 and 2 always read 0, and writing to them has no effect.
- R2: Bit 4 (button flag) sets on the synchronized rising edge of `btn_i`, but only when `slp_i` is S0 (0) or S1 (1); S3 is 2 and G3 is 3. Holding `btn_i` high after software clears the flag does not set it again.
- R3: Bits 4 and 3 are cleared while `rsm_rst_i` or `cf9_rst_i` is high. This clear takes priority over any set in the same cycle.
- R4: Bit 3 (thermal flag) sets on the synchronized rising edge of `trip_i` only when `pci_rst_i` is low and the state is S0 or S1. The flag is not cleared by `pci_rst_i` or by changes of sleep state.
- R5: Bit 1 (power-good flag) sets on the synchronized falling edge of `pok_i` in S0 or S1. It clears only on a write of 1 or on entry to G3, meaning a change of `slp_i` to 3 from any other value. Staying in a sleep state other than G3 does not clear it.
- R6: Bit 0 (regulator flag) sets on the synchronized falling edge of `vrm_ok_i` in any sleep state. It clears only on a write of 1 or on entry to G3.
- R7: A write with `wr_en_i` high clears every flag whose data bit is 1 and leaves a flag unchanged where the data bit is 0. A set in the same cycle beats the write clear.
- R8: Suppose `pok_i` falls and then rises with `rsm_rst_i` low during the whole outage. Then `reboot_o` pulses high for exactly one cycle, whatever `after_g3_i` is.
- R9: Suppose `rsm_rst_i` is high in any cycle of an outage. Then, when `pok_i` returns, `reboot_o` pulses only if `after_g3_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| btn_i | input | 1 | Reset button pressed, active high, asynchronous |
| trip_i | input | 1 | Processor thermal trip, active high, asynchronous |
| pci_rst_i | input | 1 | Bus reset output currently asserted, synchronous |
| pok_i | input | 1 | Main power-good, high when good, asynchronous |
| vrm_ok_i | input | 1 | Regulator power-good, high when good, asynchronous |
| slp_i | input | 2 | Sleep state: 0 S0, 1 S1, 2 S3, 3 G3 |
| rsm_rst_i | input | 1 | Resume-well reset, active high, synchronous |
| cf9_rst_i | input | 1 | Software full-reset request, synchronous |
| after_g3_i | input | 1 | Policy: 1 stay off after full outage, 0 boot |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data, 1 clears the flag |
| status_o | output | 8 | Flag byte |
| reboot_o | output | 1 | One-cycle reboot request |

## Verification
Two things can land on the same edge: a flag's set event and a software write-one-clear of that same flag. The bench times a write to bit 1 for the exact cycle in which the synchronized power-good fall is detected, which is the second edge after the pin drops. It expects the flag to read 1 afterwards. Hardware clears meeting sets are provoked by holding `rsm_rst_i` high through a button press, and the flag must stay 0. A behavioural model, compared on every clock, judges every other coincidence the stimulus creates.

// File: rtl/pwr_evt_pkg.sv
`timescale 1ns/1ps
package pwr_evt_pkg;

    typedef enum logic [1:0] {
        SLP_S0 = 2'd0,
        SLP_S1 = 2'd1,
        SLP_S3 = 2'd2,
        SLP_G3 = 2'd3
    } slp_e;

    // index of each event inside the synchronizer vector
    localparam int EV_BTN  = 0;
    localparam int EV_TRIP = 1;
    localparam int EV_POK  = 2;
    localparam int EV_VRM  = 3;
    localparam int EV_N    = 4;

    // bit position of each flag in the status byte
    localparam int FLG_BTN  = 4;
    localparam int FLG_TRIP = 3;
    localparam int FLG_POK  = 1;
    localparam int FLG_VRM  = 0;

    typedef struct packed {
        logic btn;
        logic trip;
        logic pok;
        logic vrm;
    } flags_t;

endpackage

// File: rtl/pwr_evt_sync.sv
`timescale 1ns/1ps
module pwr_evt_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    localparam int LAST = STAGES - 1;

    typedef logic [W-1:0] vec_t;

    typedef struct packed {
        vec_t [STAGES-1:0] chain;
        vec_t              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[LAST] & ~st_q.prev;
    assign fall_o = ~st_q.chain[LAST] & st_q.prev;
endmodule

// File: rtl/pwr_evt_fail.sv
`timescale 1ns/1ps
module pwr_evt_fail (
    input  logic clk,
    input  logic rst_n,
    input  logic pok_fall_i,
    input  logic pok_rise_i,
    input  logic rsm_rst_i,
    input  logic after_g3_i,
    output logic reboot_o
);
    typedef struct packed {
        logic lost;    // outage in progress
        logic full;    // resume-well reset seen during outage
        logic reboot;
    } fail_st_t;

    fail_st_t st_d, st_q;
    logic     full_now;

    always_comb begin
        st_d        = st_q;
        st_d.reboot = 1'b0;
        full_now    = st_q.full | rsm_rst_i;
        if (pok_rise_i) begin
            st_d.reboot = st_q.lost & (~full_now | ~after_g3_i);
            st_d.lost   = 1'b0;
            st_d.full   = 1'b0;
        end else if (pok_fall_i) begin
            st_d.lost = 1'b1;
            st_d.full = rsm_rst_i;
        end else if (st_q.lost && rsm_rst_i) begin
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reboot_o = st_q.reboot;
endmodule

// File: rtl/pwr_evt_status.sv
`timescale 1ns/1ps
module pwr_evt_status
    import pwr_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REG_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_i,
    input  logic             trip_i,
    input  logic             pci_rst_i,
    input  logic             pok_i,
    input  logic             vrm_ok_i,
    input  logic [1:0]       slp_i,
    input  logic             rsm_rst_i,
    input  logic             cf9_rst_i,
    input  logic             after_g3_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] status_o,
    output logic             reboot_o
);
    localparam logic [REG_W-1:0] FLAG_MASK =
        REG_W'((1 << FLG_BTN) | (1 << FLG_TRIP) | (1 << FLG_POK) | (1 << FLG_VRM));

    typedef struct packed {
        flags_t flg;
        slp_e   slp;
    } stat_st_t;

    logic [EV_N-1:0]  evt_w, rise_w, fall_w;
    logic             btn_rise_w, trip_rise_w;
    logic             pok_fall_w, pok_rise_w, vrm_fall_w;
    logic [REG_W-1:0] clr_w;
    logic             running, g3_entry, hw_clr;
    slp_e             slp_now;
    stat_st_t         st_d, st_q;

    always_comb begin
        evt_w          = '0;
        evt_w[EV_BTN]  = btn_i;
        evt_w[EV_TRIP] = trip_i;
        evt_w[EV_POK]  = pok_i;
        evt_w[EV_VRM]  = vrm_ok_i;
    end

    pwr_evt_sync #(.W(EV_N), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (evt_w),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    assign btn_rise_w  = rise_w[EV_BTN];
    assign trip_rise_w = rise_w[EV_TRIP];
    assign pok_fall_w  = fall_w[EV_POK];
    assign pok_rise_w  = rise_w[EV_POK];
    assign vrm_fall_w  = fall_w[EV_VRM];

    pwr_evt_fail fail_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pok_fall_i (pok_fall_w),
        .pok_rise_i (pok_rise_w),
        .rsm_rst_i  (rsm_rst_i),
        .after_g3_i (after_g3_i),
        .reboot_o   (reboot_o)
    );

    always_comb begin
        slp_now  = slp_e'(slp_i);
        running  = (slp_now == SLP_S0) || (slp_now == SLP_S1);
        g3_entry = (slp_now == SLP_G3) && (st_q.slp != SLP_G3);
        hw_clr   = rsm_rst_i | cf9_rst_i;
        clr_w    = wr_en_i ? (wr_data_i & FLAG_MASK) : '0;

        st_d     = st_q;
        st_d.slp = slp_now;

        if (hw_clr)                        st_d.flg.btn = 1'b0;
        else if (btn_rise_w && running)    st_d.flg.btn = 1'b1;
        else if (clr_w[FLG_BTN])           st_d.flg.btn = 1'b0;

        if (hw_clr)                        st_d.flg.trip = 1'b0;
        else if (trip_rise_w && running && !pci_rst_i)
                                           st_d.flg.trip = 1'b1;
        else if (clr_w[FLG_TRIP])          st_d.flg.trip = 1'b0;

        if (g3_entry)                      st_d.flg.pok = 1'b0;
        else if (pok_fall_w && running)    st_d.flg.pok = 1'b1;
        else if (clr_w[FLG_POK])           st_d.flg.pok = 1'b0;

        if (g3_entry)                      st_d.flg.vrm = 1'b0;
        else if (vrm_fall_w)               st_d.flg.vrm = 1'b1;
        else if (clr_w[FLG_VRM])           st_d.flg.vrm = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flg <= '0;
            st_q.slp <= SLP_S0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o           = '0;
        status_o[FLG_BTN]  = st_q.flg.btn;
        status_o[FLG_TRIP] = st_q.flg.trip;
        status_o[FLG_POK]  = st_q.flg.pok;
        status_o[FLG_VRM]  = st_q.flg.vrm;
    end
endmodule

// File: rtl/pwr_evt_chk.sv
`timescale 1ns/1ps
module pwr_evt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status_o,
    input logic       reboot_o,
    input logic       rsm_rst_i,
    input logic       cf9_rst_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic [1:0] slp_i,
    input logic       pok_fall,
    input logic       pok_rise,
    input logic       vrm_fall
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (status_o[7:5] == 3'b000) && !status_o[2]); // R1

    AST_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsm_rst_i || cf9_rst_i) |=> (status_o[4:3] == 2'b00)); // R3

    AST_POK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (pok_fall && slp_i < 2'd2) |=> status_o[1]); // R5

    AST_VRM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (vrm_fall && slp_i != 2'd3) |=> status_o[0]); // R6

    AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_data_i[1] && slp_i != 2'd3) |=> !$fell(status_o[1])); // R7

    AST_REBOOT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_o |=> !reboot_o); // R8

    AST_REBOOT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_o |-> $past(pok_rise)); // R9
endmodule

bind pwr_evt_status pwr_evt_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_o  (status_o),
    .reboot_o  (reboot_o),
    .rsm_rst_i (rsm_rst_i),
    .cf9_rst_i (cf9_rst_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .slp_i     (slp_i),
    .pok_fall  (pok_fall_w),
    .pok_rise  (pok_rise_w),
    .vrm_fall  (vrm_fall_w)
);

// File: tb/pwr_evt_status_tb_top.sv
`timescale 1ns/1ps
module pwr_evt_status_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_i = 0, trip_i = 0, pci_rst_i = 0, pok_i = 1, vrm_ok_i = 1;
    logic [1:0] slp_i = 2'd0;
    logic       rsm_rst_i = 0, cf9_rst_i = 0, after_g3_i = 0, wr_en_i = 0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] status_o;
    logic       reboot_o;

    int total = 0;
    int bad   = 0;
    int rb_cnt = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    pwr_evt_status dut_i (
        .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .trip_i(trip_i),
        .pci_rst_i(pci_rst_i), .pok_i(pok_i), .vrm_ok_i(vrm_ok_i),
        .slp_i(slp_i), .rsm_rst_i(rsm_rst_i), .cf9_rst_i(cf9_rst_i),
        .after_g3_i(after_g3_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .status_o(status_o), .reboot_o(reboot_o)
    );

    // behavioural reference: histories of pin samples, 0=btn 1=trip 2=pok 3=vrm
    logic [3:0] h0, h1, h2;
    logic [7:0] m_stat;
    logic       m_reboot, m_lost, m_full;
    logic [1:0] m_slp_prev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h0 = 0; h1 = 0; h2 = 0;
            m_stat = 0; m_reboot = 0; m_lost = 0; m_full = 0; m_slp_prev = 0;
        end else begin
            logic [3:0] up, dn;
            logic run, g3e, hw;
            up  = h1 & ~h2;
            dn  = ~h1 & h2;
            run = (slp_i == 2'd0) || (slp_i == 2'd1);
            g3e = (slp_i == 2'd3) && (m_slp_prev != 2'd3);
            hw  = rsm_rst_i || cf9_rst_i;
            if (hw) m_stat[4] = 0;
            else if (up[0] && run) m_stat[4] = 1;
            else if (wr_en_i && wr_data_i[4]) m_stat[4] = 0;
            if (hw) m_stat[3] = 0;
            else if (up[1] && run && !pci_rst_i) m_stat[3] = 1;
            else if (wr_en_i && wr_data_i[3]) m_stat[3] = 0;
            if (g3e) m_stat[1] = 0;
            else if (dn[2] && run) m_stat[1] = 1;
            else if (wr_en_i && wr_data_i[1]) m_stat[1] = 0;
            if (g3e) m_stat[0] = 0;
            else if (dn[3]) m_stat[0] = 1;
            else if (wr_en_i && wr_data_i[0]) m_stat[0] = 0;
            m_reboot = 0;
            if (up[2]) begin
                m_reboot = m_lost && (!(m_full || rsm_rst_i) || !after_g3_i);
                m_lost = 0; m_full = 0;
            end else if (dn[2]) begin
                m_lost = 1; m_full = rsm_rst_i;
            end else if (m_lost && rsm_rst_i) m_full = 1;
            m_slp_prev = slp_i;
            h2 = h1; h1 = h0; h0 = {vrm_ok_i, pok_i, trip_i, btn_i};
        end
    end

    function automatic string bit_tag(int b);
        case (b)
            4: return "R2";
            3: return "R4";
            1: return "R5";
            0: return "R6";
            default: return "R1";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !ended) begin
            total++;
            if (status_o !== m_stat) begin
                bad++;
                for (int b = 7; b >= 0; b--) begin
                    if (status_o[b] !== m_stat[b]) begin
                        $display("FAIL %s model compare bit %0d: actual=%h expected=%h",
                                 bit_tag(b), b, status_o, m_stat);
                        break;
                    end
                end
            end
            total++;
            if (reboot_o !== m_reboot) begin
                bad++;
                $display("FAIL R8 model compare reboot: actual=%b expected=%b", reboot_o, m_reboot);
            end
            if (reboot_o) rb_cnt++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        wr_en_i = 1; wr_data_i = d;
        tick(1);
        wr_en_i = 0; wr_data_i = 8'h00;
    endtask

    task automatic finish_run();
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int rb0;
        tick(3);
        rst_n = 1;
        tick(6);
        chk("R1 reset value", status_o, 8'h00);

        // button in S0, then held level after clear
        btn_i = 1; tick(5);
        chk("R2 button set in S0", status_o, 8'h10);
        wr(8'h10); tick(4);
        chk("R2 held button no re-set", status_o, 8'h00);
        btn_i = 0; tick(4);

        // regulator drop, zero-bit write and reserved writes
        vrm_ok_i = 0; tick(5);
        chk("R6 regulator flag set", status_o, 8'h01);
        wr(8'hFE); tick(2);
        chk("R7 zero bit keeps flag, R1 reserved stay 0", status_o, 8'h01);
        wr(8'h01); tick(2);
        chk("R7 write one clears", status_o, 8'h00);
        vrm_ok_i = 1; tick(4);

        // button outside S0/S1
        slp_i = 2'd2; btn_i = 1; tick(5);
        chk("R2 no set in S3", status_o, 8'h00);
        btn_i = 0; tick(4); slp_i = 2'd0; tick(2);

        // thermal trip qualification and survival
        pci_rst_i = 1; trip_i = 1; tick(5);
        chk("R4 no set under bus reset", status_o, 8'h00);
        trip_i = 0; tick(4); pci_rst_i = 0; trip_i = 1; tick(5);
        chk("R4 trip set", status_o, 8'h08);
        pci_rst_i = 1; slp_i = 2'd2; tick(2); slp_i = 2'd0; tick(2); pci_rst_i = 0; tick(2);
        chk("R4 trip survives reboot", status_o, 8'h08);
        cf9_rst_i = 1; tick(1); cf9_rst_i = 0; tick(2);
        chk("R3 full-reset request clears", status_o, 8'h00);
        trip_i = 0; tick(4);

        // resume reset held through a press: clear wins
        rsm_rst_i = 1; btn_i = 1; tick(5);
        chk("R3 clear beats set", status_o, 8'h00);
        rsm_rst_i = 0; tick(3);
        chk("R3 edge consumed", status_o, 8'h00);
        btn_i = 0; tick(4);

        // set beats write-one-clear in the detection cycle
        pok_i = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr_en_i = 1; wr_data_i = 8'h02;
        tick(1);
        wr_en_i = 0; wr_data_i = 8'h00;
        tick(2);
        chk("R7 set wins over clear", status_o, 8'h02);

        // partial outage, policy says stay off: still reboots
        rb0 = rb_cnt; after_g3_i = 1; pok_i = 1; tick(6);
        chk("R8 partial outage reboots", rb_cnt, rb0 + 1);
        wr(8'h02); tick(1);

        // full outage, stay-off policy
        rb0 = rb_cnt; pok_i = 0; tick(5); rsm_rst_i = 1; tick(2); rsm_rst_i = 0;
        pok_i = 1; tick(6);
        chk("R9 full outage stays off", rb_cnt, rb0);
        chk("R5 power-good flag set", status_o, 8'h02);
        wr(8'h02); tick(1);

        // full outage, boot policy
        rb0 = rb_cnt; after_g3_i = 0; pok_i = 0; tick(5); rsm_rst_i = 1; tick(2);
        rsm_rst_i = 0; pok_i = 1; tick(6);
        chk("R9 full outage boots", rb_cnt, rb0 + 1);

        // G3 entry clears, sleep does not
        vrm_ok_i = 0; tick(5);
        chk("R6 regulator set again", status_o, 8'h03);
        vrm_ok_i = 1; slp_i = 2'd2; tick(4);
        chk("R5 S3 keeps flags", status_o, 8'h03);
        slp_i = 2'd3; tick(2);
        chk("R5 G3 entry clears", status_o, 8'h00);
        pok_i = 0; tick(5);
        chk("R5 no set in G3", status_o, 8'h00);
        vrm_ok_i = 0; tick(5);
        chk("R6 sets in G3", status_o, 8'h01);
        slp_i = 2'd0; vrm_ok_i = 1; pok_i = 1; tick(6);
        wr(8'h01); tick(2);
        chk("R7 final clear", status_o, 8'h00);

        finish_run();
    end
endmodule